// File: doc/BRIEF.md
# APB Clause 45 Register Window Bridge

This block is an APB3 slave on the peripheral clock `pclk`. It lets a processor reach a 21-bit space of 16-bit PCS management registers, where an address is a 5-bit device field in bits [20:16] and a 16-bit register number in bits [15:0]. A parameter selects one of two address modes. In flat mode every register has its own bus slot. In windowed mode the bus sees a 256-slot aperture. Slot 255 of that aperture is a local selector register, and slots 0 to 254 map onto the 256-register set that the selector picks.

The bus byte address is divided by a register stride of 2 or 4 bytes (parameter, default 2) to form a slot index. Register data always travels in bits [15:0] of the 32-bit bus word. Accesses that need the PCS register file go out through a valid/ready request port (`bk_*`) and complete when that port accepts them.

Back-pressure rules on the request port:
- `bk_valid` rises one cycle after the APB access phase begins.
- While `bk_ready` is low, `bk_valid`, `bk_we`, `bk_addr` and `bk_wdata` stay unchanged.
- The request is accepted on the first rising edge where both `bk_valid` and `bk_ready` are high. `bk_rdata` is taken in that same cycle.

Top module: `c45_apb_window`

## Requirements
- R1: After reset `bk_valid` and `pready` are low, and in windowed mode the selector reads as zero.
- R2: In flat mode slot index s goes to the request port as `bk_addr` = s[20:0], so the device field lands in [20:16] and the register number in [15:0].
- R3: The slot index is the bus byte address divided by STRIDE. Read data carries the register in bits [15:0] and zeros in bits [31:16]. Write bits [31:16] are ignored, and `bk_wdata` = `pwdata[15:0]`.
- R4: In windowed mode, aperture slots 0 to 254 go to the request port as `bk_addr` = {selector[12:0], slot[7:0]}.
- R5: In windowed mode, aperture slot 255 is the selector. It holds address bits [20:8] in 13 bits, takes `pwdata[12:0]` on a write, reads back zero-extended, and completes with `pready` in the first access cycle without raising `bk_valid`.
- R6: An access whose byte address is not a multiple of STRIDE completes in the first access cycle with `pslverr` high and read data zero. It raises no request, and it changes no register, including the selector.
- R7: In flat mode a slot index of 2^21 or more gets the same error response as R6.
- R8: A register file access raises `bk_valid` in the cycle after the first access cycle. `pready` rises in the cycle where `bk_ready` is sampled high, with `prdata` = {16'b0, `bk_rdata`}. A request answered after d extra cycles therefore costs 1+d APB wait states.
- R9: In windowed mode, slot-index bits above bit 7 are ignored, so the aperture repeats across the bus address range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB transfer complete |
| pslverr | output | 1 | APB error response |
| bk_valid | output | 1 | Register file request valid |
| bk_we | output | 1 | Request is a write |
| bk_addr | output | 21 | Clause 45 register address |
| bk_wdata | output | 16 | Register write data |
| bk_ready | input | 1 | Register file accepts request |
| bk_rdata | input | 16 | Register read data, valid with bk_ready |

## Verification
Local results (selector accesses and error responses) are due in the first access cycle, so the bench samples `pready` 2 ns after the falling edge that raised `penable` and expects zero wait states. A register file access must show `bk_valid` one edge later. The bench's responder holds `bk_ready` low for a programmed d cycles and counts the APB wait states, expecting exactly 1+d. Request fields, read data and error flags are compared only in the cycle where `pready` is high, and the responder's request count shows that local and erroneous accesses never reached the port.

// File: rtl/c45_win_pkg.sv
package c45_win_pkg;
  localparam int C45_AW = 21;
  localparam int C45_DW = 16;
  localparam int SEL_W  = C45_AW - 8;

  typedef enum logic {BK_IDLE, BK_WAIT} bk_state_e;

  typedef struct packed {
    logic              we;
    logic [C45_AW-1:0] addr;
    logic [C45_DW-1:0] wdata;
  } c45_req_t;
endpackage

// File: rtl/c45_addr_decode.sv
module c45_addr_decode
  import c45_win_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int STRIDE   = 2,
  parameter bit INDIRECT = 1'b1
) (
  input  logic [ADDR_W-1:0] paddr,
  input  logic [SEL_W-1:0]  sel_q,
  output logic              misaligned,
  output logic              out_of_range,
  output logic              is_selector,
  output logic [C45_AW-1:0] tgt_addr
);
  localparam int SH = (STRIDE == 4) ? 2 : 1;

  assign misaligned = |paddr[SH-1:0];

  generate
    if (INDIRECT) begin : g_window
      logic [7:0] slot_lo;
      logic       unused_hi;
      assign slot_lo      = paddr[SH +: 8];
      assign unused_hi    = |paddr;
      assign is_selector  = (slot_lo == 8'hFF);
      assign out_of_range = 1'b0;
      assign tgt_addr     = {sel_q, slot_lo};
    end else begin : g_flat
      logic [ADDR_W-1:0] slot;
      logic              unused_sel;
      assign slot         = paddr >> SH;
      assign unused_sel   = |sel_q;
      assign is_selector  = 1'b0;
      assign out_of_range = |slot[ADDR_W-1:C45_AW];
      assign tgt_addr     = slot[C45_AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/c45_selector.sv
module c45_selector
  import c45_win_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wdata;
  end
endmodule

// File: rtl/c45_bk_ctrl.sv
module c45_bk_ctrl
  import c45_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  c45_req_t          req_in,
  input  logic              bk_ready,
  output logic              bk_valid,
  output logic              bk_we,
  output logic [C45_AW-1:0] bk_addr,
  output logic [C45_DW-1:0] bk_wdata
);
  bk_state_e state_q;
  c45_req_t  hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BK_IDLE;
      hold_q  <= '0;
    end else begin
      case (state_q)
        BK_IDLE: if (start) begin
          state_q <= BK_WAIT;
          hold_q  <= req_in;
        end
        BK_WAIT: if (bk_ready) state_q <= BK_IDLE;
        default: state_q <= BK_IDLE;
      endcase
    end
  end

  assign bk_valid = (state_q == BK_WAIT);
  assign bk_we    = hold_q.we;
  assign bk_addr  = hold_q.addr;
  assign bk_wdata = hold_q.wdata;
endmodule

// File: rtl/c45_apb_window.sv
module c45_apb_window
  import c45_win_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int STRIDE   = 2,
  parameter bit INDIRECT = 1'b1
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              bk_valid,
  output logic              bk_we,
  output logic [20:0]       bk_addr,
  output logic [15:0]       bk_wdata,
  input  logic              bk_ready,
  input  logic [15:0]       bk_rdata
);
  logic              access, misaligned, out_of_range, is_selector;
  logic              err, local_hit, start, bk_done, sel_wr;
  logic [SEL_W-1:0]  sel_q;
  logic [C45_AW-1:0] tgt_addr;
  c45_req_t          req;
  logic              unused_pw;

  assign unused_pw = |pwdata[31:16];
  assign access    = psel & penable;

  c45_addr_decode #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .INDIRECT(INDIRECT)) u_dec (
    .paddr       (paddr),
    .sel_q       (sel_q),
    .misaligned  (misaligned),
    .out_of_range(out_of_range),
    .is_selector (is_selector),
    .tgt_addr    (tgt_addr)
  );

  assign err       = misaligned | out_of_range;
  assign local_hit = err | is_selector;
  assign sel_wr    = access & pwrite & is_selector & ~err;

  generate
    if (INDIRECT) begin : g_sel
      c45_selector u_sel (
        .clk  (pclk),
        .rst_n(presetn),
        .wr_en(sel_wr),
        .wdata(pwdata[SEL_W-1:0]),
        .sel_q(sel_q)
      );
    end else begin : g_nosel
      logic unused_sw;
      assign unused_sw = sel_wr;
      assign sel_q     = '0;
    end
  endgenerate

  assign req.we    = pwrite;
  assign req.addr  = tgt_addr;
  assign req.wdata = pwdata[C45_DW-1:0];
  assign start     = access & ~local_hit & ~bk_valid;

  c45_bk_ctrl u_bk (
    .clk     (pclk),
    .rst_n   (presetn),
    .start   (start),
    .req_in  (req),
    .bk_ready(bk_ready),
    .bk_valid(bk_valid),
    .bk_we   (bk_we),
    .bk_addr (bk_addr),
    .bk_wdata(bk_wdata)
  );

  assign bk_done = bk_valid & bk_ready;
  assign pready  = access & (local_hit | bk_done);
  assign pslverr = access & err;

  always_comb begin
    prdata = '0;
    if (access && !err) begin
      if (is_selector)  prdata = {{(32-SEL_W){1'b0}}, sel_q};
      else if (bk_done) prdata = {16'b0, bk_rdata};
    end
  end
endmodule

// File: rtl/c45_apb_window_chk.sv
module c45_apb_window_chk #(
  parameter int ADDR_W   = 24,
  parameter int STRIDE   = 2,
  parameter bit INDIRECT = 1'b1
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       prdata,
  input logic              pready,
  input logic              pslverr,
  input logic              bk_valid,
  input logic              bk_we,
  input logic [20:0]       bk_addr,
  input logic [15:0]       bk_wdata,
  input logic              bk_ready
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(STRIDE - 1);

  a_r8_hold_request: assert property (@(posedge pclk) disable iff (!presetn)
    bk_valid && !bk_ready |=> bk_valid && $stable(bk_addr) && $stable(bk_we) && $stable(bk_wdata));

  a_r8_valid_in_access: assert property (@(posedge pclk) disable iff (!presetn)
    bk_valid |-> psel && penable);

  a_r6_misaligned_error: assert property (@(posedge pclk) disable iff (!presetn)
    psel && penable && ((paddr & LOW_MASK) != '0) |-> pready && pslverr && !bk_valid);

  a_r6_error_completes: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> pready && prdata == 32'h0);

  a_r5_selector_local: assert property (@(posedge pclk) disable iff (!presetn)
    bk_valid |-> (!INDIRECT || bk_addr[7:0] != 8'hFF));

  a_r3_upper_zero: assert property (@(posedge pclk) disable iff (!presetn)
    pready |-> prdata[31:16] == 16'h0);
endmodule

bind c45_apb_window c45_apb_window_chk #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .INDIRECT(INDIRECT)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .paddr(paddr),
  .prdata(prdata), .pready(pready), .pslverr(pslverr), .bk_valid(bk_valid),
  .bk_we(bk_we), .bk_addr(bk_addr), .bk_wdata(bk_wdata), .bk_ready(bk_ready)
);

// File: tb/c45_apb_window_tb.sv
module c45_apb_window_tb;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel_w = 1'b0, psel_f = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [23:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata_w, prdata_f;
  logic        pready_w, pready_f, pslverr_w, pslverr_f;
  logic        bkv_w, bkv_f, bkwe_w, bkwe_f;
  logic [20:0] bka_w, bka_f;
  logic [15:0] bkd_w, bkd_f;
  logic        rdy_w = 1'b0, rdy_f = 1'b0;
  logic [15:0] rdat_w = '0, rdat_f = '0;

  int n_cmp = 0, n_bad = 0;
  int dly_w = 0, dly_f = 0, cnt_w = 0, cnt_f = 0, nreq_w = 0, nreq_f = 0;
  logic [20:0] la_w, la_f;
  logic        lwe_w, lwe_f;
  logic [15:0] ld_w, ld_f;
  bit done = 0;

  always #4 pclk = ~pclk;

  c45_apb_window #(.ADDR_W(24), .STRIDE(2), .INDIRECT(1'b1)) u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel_w), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_w), .pready(pready_w), .pslverr(pslverr_w),
    .bk_valid(bkv_w), .bk_we(bkwe_w), .bk_addr(bka_w), .bk_wdata(bkd_w),
    .bk_ready(rdy_w), .bk_rdata(rdat_w));

  c45_apb_window #(.ADDR_W(24), .STRIDE(4), .INDIRECT(1'b0)) u_flat (
    .pclk(pclk), .presetn(presetn), .psel(psel_f), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_f), .pready(pready_f), .pslverr(pslverr_f),
    .bk_valid(bkv_f), .bk_we(bkwe_f), .bk_addr(bka_f), .bk_wdata(bkd_f),
    .bk_ready(rdy_f), .bk_rdata(rdat_f));

  function automatic logic [15:0] model(input logic [20:0] a);
    return a[15:0] ^ 16'h5AC3 ^ {11'b0, a[20:16]};
  endfunction

  always @(negedge pclk) begin
    if (bkv_w && !rdy_w) begin
      if (cnt_w == dly_w) begin
        rdy_w = 1'b1; rdat_w = model(bka_w); la_w = bka_w; lwe_w = bkwe_w; ld_w = bkd_w;
        nreq_w++; cnt_w = 0;
      end else cnt_w++;
    end else rdy_w = 1'b0;
    if (bkv_f && !rdy_f) begin
      if (cnt_f == dly_f) begin
        rdy_f = 1'b1; rdat_f = model(bka_f); la_f = bka_f; lwe_f = bkwe_f; ld_f = bkd_f;
        nreq_f++; cnt_f = 0;
      end else cnt_f++;
    end else rdy_f = 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb(input bit flat, input bit wr, input logic [23:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output logic er, output int waits);
    @(negedge pclk);
    if (flat) psel_f = 1'b1; else psel_w = 1'b1;
    penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
    @(negedge pclk);
    penable = 1'b1; waits = 0;
    #2;
    while (!(flat ? pready_f : pready_w)) begin
      @(negedge pclk); waits++; #2;
    end
    rd = flat ? prdata_f : prdata_w;
    er = flat ? pslverr_f : pslverr_w;
    @(negedge pclk);
    psel_w = 1'b0; psel_f = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; logic er; int w;
    chk("R1 bk_valid", {30'b0, bkv_w, bkv_f}, 32'h0);
    chk("R1 pready", {30'b0, pready_w, pready_f}, 32'h0);
    apb(0, 0, 24'h1FE, 0, rd, er, w);
    chk("R1 selector reset", rd, 32'h0);
  endtask

  task automatic t_selector();
    logic [31:0] rd; logic er; int w; int n0;
    n0 = nreq_w;
    apb(0, 1, 24'h1FE, 32'hFFFF_F123, rd, er, w);
    chk("R5 write waits", w, 0);
    apb(0, 0, 24'h1FE, 0, rd, er, w);
    chk("R5 selector readback", rd, 32'h0000_1123);
    chk("R5 read waits", w, 0);
    chk("R5 no request", nreq_w, n0);
  endtask

  task automatic t_window();
    logic [31:0] rd; logic er; int w;
    dly_w = 0;
    apb(0, 0, 24'h020, 0, rd, er, w);
    chk("R4 read addr", la_w, 21'h112310);
    chk("R4 read data", rd, {16'b0, model(21'h112310)});
    chk("R8 zero-delay waits", w, 1);
    apb(0, 1, 24'h1FC, 32'h0000_BEEF, rd, er, w);
    chk("R4 write addr", la_w, 21'h1123FE);
    chk("R4 write we/data", {lwe_w, 15'b0, ld_w}, {1'b1, 15'b0, 16'hBEEF});
  endtask

  task automatic t_alias();
    logic [31:0] rd; logic er; int w;
    apb(0, 0, 24'h1020, 0, rd, er, w);
    chk("R9 aliased slot addr", la_w, 21'h112310);
    apb(0, 0, 24'h3FE, 0, rd, er, w);
    chk("R9 aliased selector", rd, 32'h0000_1123);
  endtask

  task automatic t_flat();
    logic [31:0] rd; logic er; int w;
    dly_f = 0;
    apb(1, 0, 24'h1C048C, 0, rd, er, w);
    chk("R2 flat addr", la_f, 21'h070123);
    chk("R3 read data upper zero", rd, {16'b0, model(21'h070123)});
    apb(1, 1, 24'h7FFFFC, 32'hDEAD_5A5A, rd, er, w);
    chk("R2 top slot addr", la_f, 21'h1FFFFF);
    chk("R3 upper write bits dropped", ld_f, 16'h5A5A);
    chk("R7 top slot no error", er, 0);
  endtask

  task automatic t_misalign();
    logic [31:0] rd; logic er; int w; int n0, n1;
    n0 = nreq_w; n1 = nreq_f;
    apb(0, 1, 24'h021, 32'h1234, rd, er, w);
    chk("R6 error odd addr", {er, 7'b0, w[7:0]}, {1'b1, 7'b0, 8'd0});
    apb(1, 0, 24'h000492, 0, rd, er, w);
    chk("R6 error stride4", {er, 7'b0, w[7:0], rd[15:0]}, {1'b1, 7'b0, 8'd0, 16'h0});
    apb(0, 1, 24'h1FF, 32'h0000_0777, rd, er, w);
    chk("R6 selector misaligned err", er, 1);
    apb(0, 0, 24'h1FE, 0, rd, er, w);
    chk("R6 selector unchanged", rd, 32'h0000_1123);
    chk("R6 no requests", {nreq_w - n0, nreq_f - n1}, 32'h0);
  endtask

  task automatic t_range();
    logic [31:0] rd; logic er; int w; int n1;
    n1 = nreq_f;
    apb(1, 1, 24'h800000, 32'h55, rd, er, w);
    chk("R7 out of range err", {er, 7'b0, w[7:0]}, {1'b1, 7'b0, 8'd0});
    chk("R7 no request", nreq_f, n1);
  endtask

  task automatic t_wait();
    logic [31:0] rd; logic er; int w;
    dly_f = 3;
    apb(1, 0, 24'h000010, 0, rd, er, w);
    chk("R8 delayed waits", w, 4);
    chk("R8 delayed data", rd, {16'b0, model(21'h4)});
    dly_w = 2;
    apb(0, 0, 24'h000002, 0, rd, er, w);
    chk("R8 window delayed waits", w, 3);
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    t_reset();
    t_selector();
    t_window();
    t_alias();
    t_flat();
    t_misalign();
    t_range();
    t_wait();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge pclk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule